// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for a small 8-bit accumulator-style processor. When a start strobe arrives, it captures a 3-bit addressing-mode code. It then takes the address or offset bytes that follow the opcode, one per cycle, from the program-memory byte stream. From those bytes it builds the address from one of three bases: nothing (an absolute address), the 16-bit index pair it holds, or the stack pointer supplied from outside.

The address appears on `effAddr` together with a single-cycle `addrValid` pulse. In the two post-increment modes, the block then stays busy until the surrounding machine reports that the operand access has finished. At that point it adds one to the index pair, so the address used for the access is always the value from before the increment. The index pair can also be loaded directly through its own port.

Top module: `operand_addr_gen`

## Requirements
- R1: Mode code 0 (absolute) consumes two stream bytes, first byte high, and `effAddr` equals {first, second}.
- R2: Mode codes 1 (index) and 2 (index, post-increment) consume no bytes, and `effAddr` equals the index pair as it stood before any increment.
- R3: Mode codes 3 (index plus byte) and 4 (index plus byte, post-increment) consume one byte, and `effAddr` is the index pair plus that byte zero-extended, modulo 2^16.
- R4: Mode code 5 (index plus word) consumes two bytes, first byte high, and `effAddr` is the index pair plus that word, modulo 2^16.
- R5: Mode code 6 (stack plus byte) consumes one byte, and `effAddr` is `spIn` plus that byte zero-extended, modulo 2^16, with `spIn` taken in the cycle `addrValid` is high.
- R6: `addrValid` is high for exactly one cycle. That cycle is the one right after the accepted start for modes 1 and 2, and the one right after the last byte is accepted for the other modes. Cycles with `byteValid` low do not count as bytes. `effAddr` reads 0 whenever `addrValid` is low.
- R7: In modes 2 and 4, `busy` stays high after the address pulse until `operandDone` is seen. In the next cycle the index pair is one greater, with 0xFFFF wrapping to 0x0000, and `busy` is low.
- R8: `operandDone` outside the post-increment wait leaves the index pair unchanged.
- R9: The index pair resets to 0x0000. `hxLoad` writes `hxLoadData` into it for the next cycle, and the load wins over a simultaneous increment, which ends the wait.
- R10: `start` is ignored while `busy` is high, and `modeSel` matters only in the cycle a start is accepted.
- R11: Mode code 7 is reserved. A start with it is ignored, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address computation |
| modeSel | input | 3 | Addressing-mode code, sampled with start |
| byteValid | input | 1 | A stream byte is present this cycle |
| progByte | input | 8 | Program-stream byte |
| spIn | input | 16 | Stack pointer value |
| hxLoad | input | 1 | Load the index pair |
| hxLoadData | input | 16 | Value for the index pair |
| operandDone | input | 1 | Operand access finished |
| effAddr | output | 16 | Effective address, valid with addrValid |
| addrValid | output | 1 | One-cycle address strobe |
| busy | output | 1 | Computation or post-increment wait in progress |
| hxOut | output | 16 | Current index pair |

## Verification
The bench inserts idle gaps between stream bytes. A design that counted idle cycles as bytes would pulse early with a half-built offset. It runs index and stack offsets that carry across 0xFFFF, and it loads 0xFFFF before a post-increment. A design that truncated or saturated would show a wrong address or an index pair stuck at 0xFFFF. It raises start, changes modeSel and pulses operandDone at moments when they must be ignored, so a block that re-latched its mode or incremented outside the wait would show a changed address or a moved index pair. It also drives hxLoad and operandDone in the same cycle to confirm that the load wins.

// File: rtl/operand_addr_gen_pkg.sv
package operand_addr_gen_pkg;

  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_IDX   = 3'd1,
    AM_IDXP  = 3'd2,
    AM_IDXB  = 3'd3,
    AM_IDXBP = 3'd4,
    AM_IDXW  = 3'd5,
    AM_STKB  = 3'd6,
    AM_RSV   = 3'd7
  } addrMode_e;

  typedef enum logic [1:0] {
    BASE_NONE  = 2'd0,
    BASE_INDEX = 2'd1,
    BASE_STACK = 2'd2
  } baseSel_e;

  typedef struct packed {
    logic     clearOff;
    logic     shiftByte;
    logic     issue;
    logic     incHx;
    baseSel_e baseSel;
  } ctrlStrobes_t;

  function automatic logic modePostInc(addrMode_e m);
    return (m == AM_IDXP) || (m == AM_IDXBP);
  endfunction

  function automatic baseSel_e modeBase(addrMode_e m);
    case (m)
      AM_ABS:  return BASE_NONE;
      AM_STKB: return BASE_STACK;
      default: return BASE_INDEX;
    endcase
  endfunction

endpackage

// File: rtl/operand_addr_gen_ctrl.sv
module operand_addr_gen_ctrl
  import operand_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   modeSel,
  input  logic         byteValid,
  input  logic         operandDone,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  localparam int WORD_BYTES = ADDR_W / BYTE_W;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_HOLD  = 2'd3
  } state_e;

  state_e     state, stateNext;
  addrMode_e  modeQ, modeNext;
  logic [CNT_W-1:0] remain, remainNext;
  addrMode_e  modeIn;
  logic [CNT_W-1:0] needBytes;

  assign modeIn = addrMode_e'(modeSel);

  always_comb begin
    case (modeIn)
      AM_ABS, AM_IDXW:   needBytes = CNT_W'(WORD_BYTES);
      AM_IDXB, AM_IDXBP,
      AM_STKB:           needBytes = CNT_W'(1);
      default:           needBytes = '0;
    endcase
  end

  always_comb begin
    stateNext  = state;
    modeNext   = modeQ;
    remainNext = remain;
    strobes    = '{clearOff: 1'b0, shiftByte: 1'b0, issue: 1'b0,
                   incHx: 1'b0, baseSel: modeBase(modeQ)};
    case (state)
      ST_IDLE: begin
        if (start && modeIn != AM_RSV) begin
          modeNext         = modeIn;
          remainNext       = needBytes;
          strobes.clearOff = 1'b1;
          stateNext        = (needBytes == '0) ? ST_ISSUE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (byteValid) begin
          strobes.shiftByte = 1'b1;
          remainNext        = remain - CNT_W'(1);
          if (remain == CNT_W'(1)) stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobes.issue = 1'b1;
        stateNext     = modePostInc(modeQ) ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        if (operandDone) begin
          strobes.incHx = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      modeQ  <= AM_ABS;
      remain <= '0;
    end else begin
      state  <= stateNext;
      modeQ  <= modeNext;
      remain <= remainNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/operand_addr_gen_dp.sv
module operand_addr_gen_dp
  import operand_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] progByte,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              hxLoad,
  input  logic [ADDR_W-1:0] hxLoadData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] hxOut
);

  localparam int WORD_BYTES = ADDR_W / BYTE_W;

  logic [BYTE_W-1:0] offByte [WORD_BYTES];
  logic [ADDR_W-1:0] offWord;
  logic [ADDR_W-1:0] hxReg;
  logic [ADDR_W-1:0] baseVal;

  // Offset shift chain: slot 0 holds the newest (least significant) byte.
  for (genvar gi = 0; gi < WORD_BYTES; gi++) begin : g_off
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offByte[gi] <= '0;
      end else if (strobes.clearOff) begin
        offByte[gi] <= '0;
      end else if (strobes.shiftByte) begin
        if (gi == 0) offByte[gi] <= progByte;
        else         offByte[gi] <= offByte[(gi == 0) ? 0 : gi-1];
      end
    end
    assign offWord[gi*BYTE_W +: BYTE_W] = offByte[gi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              hxReg <= '0;
    else if (hxLoad)        hxReg <= hxLoadData;
    else if (strobes.incHx) hxReg <= hxReg + ADDR_W'(1);
  end

  always_comb begin
    case (strobes.baseSel)
      BASE_INDEX: baseVal = hxReg;
      BASE_STACK: baseVal = spIn;
      default:    baseVal = '0;
    endcase
  end

  assign effAddr = strobes.issue ? (baseVal + offWord) : '0;
  assign hxOut   = hxReg;

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import operand_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        modeSel,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] progByte,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              hxLoad,
  input  logic [ADDR_W-1:0] hxLoadData,
  input  logic              operandDone,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic              busy,
  output logic [ADDR_W-1:0] hxOut
);

  ctrlStrobes_t strobes;

  operand_addr_gen_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .byteValid(byteValid), .operandDone(operandDone),
    .strobes(strobes), .busy(busy)
  );

  operand_addr_gen_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progByte(progByte),
    .spIn(spIn), .hxLoad(hxLoad), .hxLoadData(hxLoadData),
    .effAddr(effAddr), .hxOut(hxOut)
  );

  assign addrValid = strobes.issue;

endmodule

// File: rtl/operand_addr_gen_chk.sv
module operand_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        modeSel,
  input logic              hxLoad,
  input logic [ADDR_W-1:0] hxLoadData,
  input logic              operandDone,
  input logic [ADDR_W-1:0] effAddr,
  input logic              addrValid,
  input logic              busy,
  input logic [ADDR_W-1:0] hxOut
);

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  p_quiet_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> (effAddr == '0));

  p_idle_no_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !addrValid);

  p_no_offset_fast_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (modeSel == 3'd1 || modeSel == 3'd2)) |=> addrValid);

  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    hxLoad |=> (hxOut == $past(hxLoadData)));

  p_idle_done_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !hxLoad) |=> (hxOut == $past(hxOut)));

  p_hold_hx_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!hxLoad && !operandDone) |=> (hxOut == $past(hxOut)));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && modeSel == 3'd7) |=> !busy);

endmodule

bind operand_addr_gen operand_addr_gen_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
  .hxLoad(hxLoad), .hxLoadData(hxLoadData), .operandDone(operandDone),
  .effAddr(effAddr), .addrValid(addrValid), .busy(busy), .hxOut(hxOut)
);

// File: tb/tb_operand_addr_gen.sv
module tb_operand_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  modeSel = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  progByte = '0;
  logic [15:0] spIn = '0;
  logic        hxLoad = 1'b0;
  logic [15:0] hxLoadData = '0;
  logic        operandDone = 1'b0;
  logic [15:0] effAddr;
  logic        addrValid;
  logic        busy;
  logic [15:0] hxOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] hxM = '0;

  always #2 clk = ~clk;

  operand_addr_gen dut (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .byteValid(byteValid), .progByte(progByte), .spIn(spIn),
    .hxLoad(hxLoad), .hxLoadData(hxLoadData), .operandDone(operandDone),
    .effAddr(effAddr), .addrValid(addrValid), .busy(busy), .hxOut(hxOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nBytes(logic [2:0] m);
    case (m)
      3'd0, 3'd5: return 2;
      3'd3, 3'd4, 3'd6: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] expAddr(logic [2:0] m, logic [15:0] hx,
                                          logic [15:0] sp, logic [7:0] hi, logic [7:0] lo);
    case (m)
      3'd0: return {hi, lo};
      3'd1, 3'd2: return hx;
      3'd3, 3'd4: return hx + {8'h00, lo};
      3'd5: return hx + {hi, lo};
      3'd6: return sp + {8'h00, lo};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string reqOf(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      3'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic loadHx(logic [15:0] v);
    @(negedge clk);
    hxLoad = 1'b1; hxLoadData = v;
    @(negedge clk);
    hxLoad = 1'b0;
    hxM = v;
    chk("R9 load", hxOut, v);
  endtask

  // One complete operation; noisy adds ignored start/modeSel traffic (R10).
  task automatic runOp(logic [2:0] m, logic [7:0] hi, logic [7:0] lo,
                       int maxGap, bit noisy);
    int n;
    logic [15:0] e;
    n = nBytes(m);
    @(negedge clk);
    start = 1'b1; modeSel = m;
    @(negedge clk);
    start = 1'b0; modeSel = 3'($urandom);
    if (m == 3'd7) begin
      chk("R11 busy", {15'b0, busy}, 16'h0);
      chk("R11 strobe", {15'b0, addrValid}, 16'h0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = (maxGap > 0) ? int'($urandom % (maxGap + 1)) : 0;
      for (int g = 0; g < gap; g++) begin
        byteValid = 1'b0;
        progByte = 8'($urandom);
        if (noisy) begin start = 1'($urandom); modeSel = 3'($urandom); end
        spIn = 16'($urandom);
        chk("R6 no early strobe", {15'b0, addrValid}, 16'h0);
        @(negedge clk);
      end
      byteValid = 1'b1;
      progByte = (n == 2 && i == 0) ? hi : lo;
      if (noisy) begin start = 1'($urandom); modeSel = 3'($urandom); end
      @(negedge clk);
    end
    byteValid = 1'b0;
    start = 1'b0;
    e = expAddr(m, hxM, spIn, hi, lo);
    chk("R6 strobe timing", {15'b0, addrValid}, 16'h1);
    chk(reqOf(m), effAddr, e);
    @(negedge clk);
    chk("R6 one cycle", {15'b0, addrValid}, 16'h0);
    chk("R6 zero addr", effAddr, 16'h0);
    if (m == 3'd2 || m == 3'd4) begin
      int w;
      chk("R7 wait busy", {15'b0, busy}, 16'h1);
      chk("R7 pre-increment hx", hxOut, hxM);
      w = int'($urandom % 4);
      for (int k = 0; k < w; k++) begin
        if (noisy) begin start = 1'($urandom); modeSel = 3'($urandom); end
        @(negedge clk);
      end
      start = 1'b0;
      operandDone = 1'b1;
      @(negedge clk);
      operandDone = 1'b0;
      hxM = hxM + 16'd1;
      chk("R7 increment", hxOut, hxM);
      chk("R7 busy drop", {15'b0, busy}, 16'h0);
    end else begin
      chk("R6 done busy", {15'b0, busy}, 16'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R9 reset hx", hxOut, 16'h0);
    chk("R6 reset strobe", {15'b0, addrValid}, 16'h0);
    chk("R6 reset addr", effAddr, 16'h0);
    chk("R10 reset busy", {15'b0, busy}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runOp(3'd0, 8'hAB, 8'hCD, 2, 1'b0);
    loadHx(16'h1234);
    runOp(3'd1, 8'h00, 8'h00, 0, 1'b0);
    runOp(3'd2, 8'h00, 8'h00, 0, 1'b0);
    loadHx(16'hFFF0);
    runOp(3'd3, 8'h00, 8'h20, 1, 1'b0);      // R3 wrap
    runOp(3'd5, 8'h00, 8'h30, 3, 1'b0);      // R4 wrap
    spIn = 16'hFFFF;
    runOp(3'd6, 8'h00, 8'h02, 0, 1'b0);      // R5 wrap
    loadHx(16'hFFFF);
    runOp(3'd4, 8'h00, 8'h01, 0, 1'b0);      // R7 wrap to 0
    runOp(3'd7, 8'h00, 8'h00, 0, 1'b0);      // R11
    runOp(3'd5, 8'h12, 8'h34, 2, 1'b1);      // R10 noise during fetch

    // R8: operandDone while idle is ignored
    @(negedge clk);
    operandDone = 1'b1;
    @(negedge clk);
    operandDone = 1'b0;
    chk("R8 idle done", hxOut, hxM);

    // R8: operandDone during fetch of a non-post-increment mode is ignored
    @(negedge clk);
    start = 1'b1; modeSel = 3'd5;
    @(negedge clk);
    start = 1'b0; operandDone = 1'b1; byteValid = 1'b1; progByte = 8'h01;
    @(negedge clk);
    progByte = 8'h02;
    @(negedge clk);
    byteValid = 1'b0; operandDone = 1'b0;
    chk("R4 with done noise", effAddr, hxM + 16'h0102);
    @(negedge clk);
    chk("R8 fetch done", hxOut, hxM);

    // R9: load wins over simultaneous increment
    @(negedge clk);
    start = 1'b1; modeSel = 3'd2;
    @(negedge clk);
    start = 1'b0;
    chk("R2 strobe", effAddr, hxM);
    @(negedge clk);
    hxLoad = 1'b1; hxLoadData = 16'h5A5A; operandDone = 1'b1;
    @(negedge clk);
    hxLoad = 1'b0; operandDone = 1'b0;
    hxM = 16'h5A5A;
    chk("R9 load priority", hxOut, 16'h5A5A);
    chk("R9 wait ended", {15'b0, busy}, 16'h0);

    // Constrained random mix
    for (int t = 0; t < 400; t++) begin
      logic [2:0] m;
      if (($urandom % 5) == 0) loadHx(16'($urandom));
      m = (($urandom % 12) == 0) ? 3'd7 : 3'($urandom % 7);
      spIn = 16'($urandom);
      runOp(m, 8'($urandom), 8'($urandom), 3, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule